// File: doc/BRIEF.md
# Tagged Quadword Command FIFO Sequencer

This block buffers 128-bit quadwords bound for a vector unit and hands them out one 32-bit word at a time. Every stored word has a two-bit class. When a quadword arrives with its DMA-tag flag set, its two low words are marked as tags. A command parser then consumes the stream through a word-level read position and never sees those tag words.

Writes arrive as byte-lane strobes. A staging register gathers them, and the quadword is committed only when all sixteen lanes are filled. The parser has two commands. It can advance the read position by N words, where tag words are stepped over and not counted; the word the position lands on is then marked as an opcode. It can also look ahead to operand N without moving the position. The lookahead reports underflow when it runs out of data, and sets a sticky mismatch error if it walks over a tag. Once every word of a quadword has been consumed, the quadword is freed, so the storage works as a circular buffer. A walker handles one word per clock. While it works, `busy_o` is high and new commands are ignored.

Top module: `qw_cmd_fifo`

## Requirements
- R1: After reset, head_valid_o, qc_o, err_o, full_o and busy_o are 0, wr_ready_o is 1, and the read position is quadword 0, word 0.
- R2: A quadword is committed only once all 16 byte strobes have been seen across one or more accepted writes. A later strobe on a lane overwrites that lane's earlier byte. Until commit, the FIFO stays empty.
- R3: When DEPTH quadwords are held, full_o is 1 and wr_ready_o is 0, and any write presented then is dropped with no effect on the stored data.
- R4: On commit, all four word classes are set to unknown (code 0). If wr_tag_i is 1 at the committing write, words 0 and 1 are set to DMA tag (code 1). Word w of a quadword is data bits [32w+31:32w].
- R5: An advance of N moves the read position over N non-tag words. The word index wraps from 3 to 0, and when it does the quadword index increments.
- R6: During an advance, words of class DMA tag are passed over and do not count toward N. An advance of 0 still passes over tag words at the current position.
- R7: An advance ends in one of two ways. If it reaches the end of stored data, qc_o is cleared and head_valid_o is 0. Otherwise the landing word is set to opcode (code 2) and shown on head_word_o and head_cls_o. qc_o is set by every commit.
- R8: Each quadword is freed when the read position leaves its last word, so new quadwords can be written after full_o falls.
- R9: A lookahead of N returns the Nth non-tag word, counting from the current position as 0, on look_word_o with look_valid_o. The read position is left unchanged.
- R10: A tag word met during a lookahead sets err_o, which stays set until reset, and the walk continues past it. The returned word is set to operand (code 3).
- R11: A lookahead that reaches the end of stored data pulses look_uflow_o and does not pulse look_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte-lane write strobe valid |
| wr_strb_i | input | 16 | Byte lanes written |
| wr_data_i | input | 128 | Write data |
| wr_tag_i | input | 1 | Low two words are DMA tags (sampled at commit) |
| wr_ready_o | output | 1 | Write accepted this cycle |
| full_o | output | 1 | DEPTH quadwords held |
| adv_i | input | 1 | Start advance |
| adv_cnt_i | input | 8 | Words to advance |
| look_i | input | 1 | Start lookahead |
| look_idx_i | input | 8 | Operand index |
| busy_o | output | 1 | Walker running, commands ignored |
| adv_done_o | output | 1 | Advance finished (pulse) |
| look_valid_o | output | 1 | Lookahead word valid (pulse) |
| look_word_o | output | 32 | Lookahead word |
| look_uflow_o | output | 1 | Lookahead ran out of data (pulse) |
| head_valid_o | output | 1 | Word at read position exists |
| head_word_o | output | 32 | Word at read position |
| head_cls_o | output | 2 | Class of word at read position |
| qc_o | output | 1 | Queue-count status |
| err_o | output | 1 | Sticky tag-mismatch error |

## Verification
The hardest state to reach is a full buffer whose read position sits partway through the oldest quadword, with a tagged quadword still being consumed. Only there do freeing, wrap-around and back-pressure interact. The stimulus first empties the buffer completely and re-fills it starting from a tagged quadword. It then writes until full, tries one more write, and advances just far enough to free a single slot. A final deep lookahead runs across the wrapped storage and shows that the dropped write never landed.

// File: rtl/qwf_pkg.sv
package qwf_pkg;
  typedef enum logic [1:0] {
    WC_UNK = 2'd0,
    WC_DMA = 2'd1,
    WC_OPC = 2'd2,
    WC_OPD = 2'd3
  } wclass_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADV  = 2'd1,
    S_LOOK = 2'd2
  } wstate_e;
endpackage

// File: rtl/qwf_stage.sv
module qwf_stage #(
  parameter int unsigned QW_W  = 128,
  localparam int unsigned LANES = QW_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LANES-1:0] wr_strb_i,
  input  logic [QW_W-1:0]  wr_data_i,
  input  logic             wr_tag_i,
  input  logic             ready_i,
  output logic             push_o,
  output logic [QW_W-1:0]  push_data_o,
  output logic             push_tag_o
);
  logic [LANES-1:0] mask_q, mask_m;
  logic [QW_W-1:0]  data_q, data_m;
  logic             accept;

  assign accept = wr_en_i && ready_i;
  assign mask_m = mask_q | (accept ? wr_strb_i : '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_m[l*8 +: 8] = (accept && wr_strb_i[l]) ? wr_data_i[l*8 +: 8]
                                                       : data_q[l*8 +: 8];
  end

  assign push_o      = accept && (&mask_m);
  assign push_data_o = data_m;
  assign push_tag_o  = wr_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      mask_q <= (&mask_m) ? '0 : mask_m;
      data_q <= data_m;
    end
  end
endmodule

// File: rtl/qwf_store.sv
module qwf_store
  import qwf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPQ    = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned WIW   = $clog2(WPQ),
  localparam int unsigned QW_W  = WORD_W * WPQ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [QW_W-1:0]   push_data_i,
  input  logic              push_tag_i,
  input  logic              pop_i,
  input  logic              cls_we_i,
  input  logic [AW-1:0]     cls_q_i,
  input  logic [WIW-1:0]    cls_w_i,
  input  wclass_e           cls_val_i,
  input  logic [WIW-1:0]    hd_w_i,
  input  logic [PW-1:0]     lk_q_i,
  input  logic [WIW-1:0]    lk_w_i,
  output logic [PW-1:0]     rd_ptr_o,
  output logic [PW-1:0]     wr_ptr_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [WORD_W-1:0] hd_data_o,
  output wclass_e           hd_cls_o,
  output logic [WORD_W-1:0] lk_data_o,
  output wclass_e           lk_cls_o
);
  logic [WORD_W-1:0] data_q [DEPTH][WPQ];
  wclass_e           cls_q  [DEPTH][WPQ];
  logic [PW-1:0]     rd_ptr_q, wr_ptr_q, count;

  assign count    = wr_ptr_q - rd_ptr_q;
  assign full_o   = count == PW'(DEPTH);
  assign empty_o  = count == '0;
  assign rd_ptr_o = rd_ptr_q;
  assign wr_ptr_o = wr_ptr_q;

  assign hd_data_o = data_q[rd_ptr_q[AW-1:0]][hd_w_i];
  assign hd_cls_o  = cls_q[rd_ptr_q[AW-1:0]][hd_w_i];
  assign lk_data_o = data_q[lk_q_i[AW-1:0]][lk_w_i];
  assign lk_cls_o  = cls_q[lk_q_i[AW-1:0]][lk_w_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  // storage carries no reset; validity comes from the pointers
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      for (int w = 0; w < int'(WPQ); w++) begin
        data_q[wr_ptr_q[AW-1:0]][w] <= push_data_i[w*WORD_W +: WORD_W];
        cls_q[wr_ptr_q[AW-1:0]][w]  <= (push_tag_i && w < 2) ? WC_DMA : WC_UNK;
      end
    end
    if (cls_we_i) cls_q[cls_q_i][cls_w_i] <= cls_val_i;
  end

  a_r3_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/qwf_walker.sv
module qwf_walker
  import qwf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPQ    = 4,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned WIW   = $clog2(WPQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  adv_cnt_i,
  input  logic              look_i,
  input  logic [CNT_W-1:0]  look_idx_i,
  input  logic [PW-1:0]     rd_ptr_i,
  input  logic [PW-1:0]     wr_ptr_i,
  input  logic [WORD_W-1:0] lk_data_i,
  input  wclass_e           lk_cls_i,
  output logic [WIW-1:0]    hd_w_o,
  output logic [PW-1:0]     lk_q_o,
  output logic [WIW-1:0]    lk_w_o,
  output logic              pop_o,
  output logic              cls_we_o,
  output logic [AW-1:0]     cls_q_o,
  output logic [WIW-1:0]    cls_w_o,
  output wclass_e           cls_val_o,
  output logic              adv_end_o,
  output logic              tag_hit_o,
  output logic              busy_o,
  output logic              adv_done_o,
  output logic              adv_at_end_o,
  output logic              op_valid_o,
  output logic [WORD_W-1:0] op_word_o,
  output logic              op_uflow_o
);
  localparam logic [WIW-1:0] LAST_W = WIW'(WPQ - 1);

  wstate_e           st_q;
  logic [CNT_W-1:0]  rem_q;
  logic [WIW-1:0]    hw_q, cw_q;
  logic [PW-1:0]     cq_q;
  logic              at_end, is_tag, active, step, land, last_w;

  assign lk_q_o = (st_q == S_LOOK) ? cq_q : rd_ptr_i;
  assign lk_w_o = (st_q == S_LOOK) ? cw_q : hw_q;
  assign hd_w_o = hw_q;

  assign at_end = lk_q_o == wr_ptr_i;
  assign is_tag = lk_cls_i == WC_DMA;
  assign active = st_q != S_IDLE;
  assign step   = active && !at_end && (is_tag || rem_q != '0);
  assign land   = active && !at_end && !is_tag && rem_q == '0;
  assign last_w = lk_w_o == LAST_W;

  assign pop_o     = (st_q == S_ADV) && step && last_w;
  assign cls_we_o  = land;
  assign cls_val_o = (st_q == S_ADV) ? WC_OPC : WC_OPD;
  assign cls_q_o   = lk_q_o[AW-1:0];
  assign cls_w_o   = lk_w_o;
  assign adv_end_o = (st_q == S_ADV) && at_end;
  assign tag_hit_o = (st_q == S_LOOK) && !at_end && is_tag;
  assign busy_o    = active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      rem_q        <= '0;
      hw_q         <= '0;
      cw_q         <= '0;
      cq_q         <= '0;
      adv_done_o   <= 1'b0;
      adv_at_end_o <= 1'b0;
      op_valid_o   <= 1'b0;
      op_word_o    <= '0;
      op_uflow_o   <= 1'b0;
    end else begin
      adv_done_o <= 1'b0;
      op_valid_o <= 1'b0;
      op_uflow_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (adv_i) begin
            rem_q <= adv_cnt_i;
            st_q  <= S_ADV;
          end else if (look_i) begin
            rem_q <= look_idx_i;
            cq_q  <= rd_ptr_i;
            cw_q  <= hw_q;
            st_q  <= S_LOOK;
          end
        end
        default: begin
          if (at_end || land) begin
            st_q <= S_IDLE;
            if (st_q == S_ADV) begin
              adv_done_o   <= 1'b1;
              adv_at_end_o <= at_end;
            end else if (at_end) begin
              op_uflow_o <= 1'b1;
            end else begin
              op_valid_o <= 1'b1;
              op_word_o  <= lk_data_i;
            end
          end else begin
            if (!is_tag) rem_q <= rem_q - CNT_W'(1);
            if (st_q == S_ADV) begin
              hw_q <= hw_q + WIW'(1);
            end else begin
              cw_q <= cw_q + WIW'(1);
              if (last_w) cq_q <= cq_q + PW'(1);
            end
          end
        end
      endcase
    end
  end

  a_r11_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({adv_done_o, op_valid_o, op_uflow_o}));
  a_r9_look_keeps_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOOK) |=> $stable(hw_q) && $stable(rd_ptr_i));
endmodule

// File: rtl/qw_cmd_fifo.sv
module qw_cmd_fifo
  import qwf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPQ    = 4,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned QW_W  = WORD_W * WPQ,
  localparam int unsigned LANES = QW_W / 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned WIW   = $clog2(WPQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  wr_strb_i,
  input  logic [QW_W-1:0]   wr_data_i,
  input  logic              wr_tag_i,
  output logic              wr_ready_o,
  output logic              full_o,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  adv_cnt_i,
  input  logic              look_i,
  input  logic [CNT_W-1:0]  look_idx_i,
  output logic              busy_o,
  output logic              adv_done_o,
  output logic              look_valid_o,
  output logic [WORD_W-1:0] look_word_o,
  output logic              look_uflow_o,
  output logic              head_valid_o,
  output logic [WORD_W-1:0] head_word_o,
  output logic [1:0]        head_cls_o,
  output logic              qc_o,
  output logic              err_o
);
  logic              push, push_tag, pop, cls_we, adv_end, tag_hit, empty, adv_at_end;
  logic [QW_W-1:0]   push_data;
  logic [AW-1:0]     cls_q;
  logic [WIW-1:0]    cls_w, hd_w, lk_w;
  logic [PW-1:0]     rd_ptr, wr_ptr, lk_q;
  logic [WORD_W-1:0] lk_data;
  wclass_e           cls_val, hd_cls, lk_cls;
  logic              qc_q, err_q;

  assign wr_ready_o   = !full_o;
  assign head_valid_o = !empty;
  assign head_cls_o   = hd_cls;
  assign qc_o         = qc_q;
  assign err_o        = err_q;

  qwf_stage #(.QW_W(QW_W)) u_stage (
    .clk_i, .rst_ni, .wr_en_i, .wr_strb_i, .wr_data_i, .wr_tag_i,
    .ready_i(wr_ready_o), .push_o(push), .push_data_o(push_data),
    .push_tag_o(push_tag)
  );

  qwf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .WPQ(WPQ)) u_store (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(push_data), .push_tag_i(push_tag),
    .pop_i(pop), .cls_we_i(cls_we), .cls_q_i(cls_q), .cls_w_i(cls_w),
    .cls_val_i(cls_val), .hd_w_i(hd_w), .lk_q_i(lk_q), .lk_w_i(lk_w),
    .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr), .full_o(full_o), .empty_o(empty),
    .hd_data_o(head_word_o), .hd_cls_o(hd_cls), .lk_data_o(lk_data),
    .lk_cls_o(lk_cls)
  );

  qwf_walker #(.DEPTH(DEPTH), .WORD_W(WORD_W), .WPQ(WPQ), .CNT_W(CNT_W)) u_walker (
    .clk_i, .rst_ni, .adv_i, .adv_cnt_i, .look_i, .look_idx_i,
    .rd_ptr_i(rd_ptr), .wr_ptr_i(wr_ptr), .lk_data_i(lk_data), .lk_cls_i(lk_cls),
    .hd_w_o(hd_w), .lk_q_o(lk_q), .lk_w_o(lk_w), .pop_o(pop),
    .cls_we_o(cls_we), .cls_q_o(cls_q), .cls_w_o(cls_w), .cls_val_o(cls_val),
    .adv_end_o(adv_end), .tag_hit_o(tag_hit), .busy_o(busy_o),
    .adv_done_o(adv_done_o), .adv_at_end_o(adv_at_end),
    .op_valid_o(look_valid_o), .op_word_o(look_word_o), .op_uflow_o(look_uflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qc_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (push)         qc_q <= 1'b1;
      else if (adv_end) qc_q <= 1'b0;
      if (tag_hit) err_q <= 1'b1;
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r7_land_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_done_o && !adv_at_end) |-> (head_valid_o && hd_cls == WC_OPC));
  a_r7_end_clears_qc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_done_o && adv_at_end && !$past(push)) |-> !qc_o);
endmodule

// File: tb/sim_qw_cmd_fifo.sv
module sim_qw_cmd_fifo;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [15:0]  wr_strb_i = '0;
  logic [127:0] wr_data_i = '0;
  logic         wr_tag_i = 1'b0;
  logic         adv_i = 1'b0;
  logic [7:0]   adv_cnt_i = '0;
  logic         look_i = 1'b0;
  logic [7:0]   look_idx_i = '0;
  logic         wr_ready_o, full_o, busy_o, adv_done_o, look_valid_o, look_uflow_o;
  logic         head_valid_o, qc_o, err_o;
  logic [31:0]  look_word_o, head_word_o;
  logic [1:0]   head_cls_o;

  always #2 clk = ~clk;

  qw_cmd_fifo u0 (.clk_i(clk), .*);

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         kind;   // 0 advance, 1 look word, 2 underflow
    logic [31:0] word;
    logic [1:0]  cls;
    bit          hv;
    string       req;
  } exp_t;
  exp_t sb[$];

  // reference model
  logic [31:0] m_word[$];
  logic [1:0]  m_cls[$];
  int          m_pos = 0;
  int          m_nq = 0;
  bit          m_qc = 0;
  bit          m_err = 0;
  logic [15:0]  s_mask = '0;
  logic [127:0] s_data = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_qw(input int q);
    logic [127:0] d;
    for (int w = 0; w < 4; w++) d[w*32 +: 32] = 32'hC0DE_0000 | (q << 8) | w;
    return d;
  endfunction

  function automatic int m_occ();
    return m_nq - m_pos / 4;
  endfunction

  task automatic m_write(input logic [15:0] strb, input logic [127:0] d, input bit tag);
    if (m_occ() == DEPTH) return;
    for (int l = 0; l < 16; l++)
      if (strb[l]) s_data[l*8 +: 8] = d[l*8 +: 8];
    s_mask |= strb;
    if (&s_mask) begin
      for (int w = 0; w < 4; w++) begin
        m_word.push_back(s_data[w*32 +: 32]);
        m_cls.push_back((tag && w < 2) ? 2'd1 : 2'd0);
      end
      m_nq++;
      m_qc = 1;
      s_mask = '0;
    end
  endtask

  task automatic write(input logic [15:0] strb, input logic [127:0] d, input bit tag);
    @(negedge clk);
    chk(wr_ready_o == (m_occ() != DEPTH), "R3 ready", wr_ready_o, m_occ() != DEPTH);
    m_write(strb, d, tag);
    wr_en_i = 1; wr_strb_i = strb; wr_data_i = d; wr_tag_i = tag;
    @(negedge clk);
    wr_en_i = 0; wr_strb_i = '0;
    chk(full_o == (m_occ() == DEPTH), "R3 full", full_o, m_occ() == DEPTH);
    chk(head_valid_o == (m_pos < 4 * m_nq), "R2 head_valid", head_valid_o,
        m_pos < 4 * m_nq);
  endtask

  task automatic finish_cmd();
    @(negedge clk);
    adv_i = 0; look_i = 0;
    while (busy_o) @(negedge clk);
    chk(qc_o == m_qc, "R7 qc", qc_o, m_qc);
    chk(err_o == m_err, "R10 err", err_o, m_err);
  endtask

  task automatic advance(input int n, input string req);
    exp_t e;
    int   end_pos = 4 * m_nq;
    e.kind = 0; e.req = req; e.hv = 0; e.word = '0; e.cls = '0;
    forever begin
      if (m_pos == end_pos) begin m_qc = 0; break; end
      if (m_cls[m_pos] == 2'd1) m_pos++;
      else if (n > 0) begin m_pos++; n--; end
      else begin
        m_cls[m_pos] = 2'd2;
        e.hv = 1; e.word = m_word[m_pos]; e.cls = 2'd2;
        break;
      end
    end
    sb.push_back(e);
    @(negedge clk);
    adv_i = 1; adv_cnt_i = 8'(e.kind == 0 ? 0 : 0) | 8'(n_adv_req);
    finish_cmd();
  endtask

  int n_adv_req = 0;

  task automatic look(input int n, input string req);
    exp_t e;
    int   c = m_pos;
    int   end_pos = 4 * m_nq;
    e.kind = 2; e.req = req; e.hv = 0; e.word = '0; e.cls = '0;
    forever begin
      if (c == end_pos) break;
      if (m_cls[c] == 2'd1) begin m_err = 1; c++; end
      else if (n > 0) begin n--; c++; end
      else begin
        m_cls[c] = 2'd3;
        e.kind = 1; e.word = m_word[c];
        break;
      end
    end
    sb.push_back(e);
  endtask

  task automatic do_adv(input int n, input string req);
    n_adv_req = n;
    advance(n, req);
  endtask

  task automatic do_look(input int n, input string req);
    look(n, req);
    @(negedge clk);
    look_i = 1; look_idx_i = 8'(n);
    finish_cmd();
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_ni && (adv_done_o || look_valid_o || look_uflow_o)) begin
      int   k;
      exp_t e;
      k = adv_done_o ? 0 : (look_valid_o ? 1 : 2);
      if (sb.size() == 0) begin
        chk(0, "R5 unexpected result", k, 99);
      end else begin
        e = sb.pop_front();
        chk(k == e.kind, {e.req, " kind"}, k, e.kind);
        if (e.kind == 0) begin
          chk(head_valid_o == e.hv, {e.req, " head_valid"}, head_valid_o, e.hv);
          if (e.hv) begin
            chk(head_word_o == e.word, {e.req, " head_word"}, head_word_o, e.word);
            chk(head_cls_o == e.cls, {e.req, " head_cls"}, head_cls_o, e.cls);
          end
        end else if (e.kind == 1) begin
          chk(look_word_o == e.word, {e.req, " look_word"}, look_word_o, e.word);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1-run act=timeout exp=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(head_valid_o == 0, "R1 head_valid", head_valid_o, 0);
    chk(qc_o == 0, "R1 qc", qc_o, 0);
    chk(err_o == 0, "R1 err", err_o, 0);
    chk(full_o == 0 && wr_ready_o == 1, "R1 full/ready", {full_o, wr_ready_o}, 2'b01);
    chk(busy_o == 0, "R1 busy", busy_o, 0);

    // R2 staged quadword: low lanes with junk, overwrite, then high lanes
    write(16'h000F, 128'hFFFF_FFFF, 0);
    chk(head_valid_o == 0, "R2 partial hidden", head_valid_o, 0);
    d = mk_qw(0);
    write(16'h00FF, d, 0);
    chk(head_valid_o == 0, "R2 partial hidden", head_valid_o, 0);
    write(16'hFF00, d, 0);
    chk(head_word_o == d[31:0], "R2 committed word", head_word_o, d[31:0]);
    chk(head_cls_o == 2'd0, "R4 unknown class", head_cls_o, 0);
    chk(qc_o == 1, "R7 qc set by commit", qc_o, 1);

    do_adv(0, "R7 adv0 opcode");
    do_look(2, "R9 look2");
    chk(head_word_o == d[31:0], "R9 position kept", head_word_o, d[31:0]);
    chk(head_cls_o == 2'd2, "R9 head still opcode", head_cls_o, 2);

    write(16'hFFFF, mk_qw(1), 1);
    do_adv(3, "R5 adv3");
    do_look(1, "R10 look over tags");
    do_adv(1, "R6 adv skips tags R8");
    do_look(5, "R11 underflow");
    do_adv(9, "R7 adv to end");

    write(16'hFFFF, mk_qw(2), 1);
    chk(head_cls_o == 2'd1, "R4 tag class", head_cls_o, 1);
    do_adv(0, "R6 adv0 skips tags");

    for (int q = 3; q < 18; q++) write(16'hFFFF, mk_qw(q), 0);
    chk(full_o == 1, "R3 full after DEPTH", full_o, 1);
    write(16'hFFFF, 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 0);
    do_adv(2, "R8 free one slot");
    chk(full_o == 0, "R8 full drops", full_o, 0);
    write(16'hFFFF, mk_qw(18), 0);
    do_look(60, "R3 R8 wrapped look");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5 results drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule